// File: doc/BRIEF.md
# Serial Word Fault Injector for a Dual-Redundant Command/Response Bus

This block sits in line between a bus transmitter and the bus itself. It watches the Manchester-coded stream one half-bit at a time, works out where each 20-bit-time word begins and which class the word belongs to, and overwrites chosen parts of that word on the way through. The parts it can hit are the sync field, any subset of the sixteen data bits, and the parity bit. It can force them to a stuck-0 value, force them to a stuck-1 value, or invert them. The block is built to test how receivers tolerate errors, so the fault is placed by field and by word class rather than at random.

The line is carried as a driven-high / driven-low pair, the way a receiver chip reports it: `p=1,n=0` is high, `p=0,n=1` is low and `p=0,n=0` is idle. A word starts on the first driven sample after idle, or straight after the last half-bit of the previous word. The first half of the sync gives the word class. High first marks a command or status word. Low first marks a data word. Because command and status words share one sync shape, a configuration bit says whether the upstream transmitter is a terminal, whose high-first words are status words, or a controller, whose high-first words are commands. The configuration is latched on the first sample of each word. An event counter counts the words that were armed for injection.

Top module: `mil_word_injector`

## Requirements
- R1: While reset is high and on the first clock after it, both line outputs are 0 and the event count is 0.
- R2: Every input sample is copied to the outputs exactly one clock later when it is idle, or when it belongs to a word that is not armed. An armed word is one whose fault code is not "off", whose class is enabled and which has at least one field selected.
- R3: A word's class comes from its first sample. High selects command/status and low selects data. Class enable bits are [0] command, [1] status and [2] data. With the source bit at 0 a high-first word is a command, and with it at 1 such a word is a status word. Any combination of enable bits may be set.
- R4: With the sync field selected, stuck-1 forces the sync to high for 1.5 bit-times and then low, stuck-0 forces it to low then high, and invert flips all six sync half-bits.
- R5: Data mask bit i selects data bit i, and data bits are sent most significant first. On a selected bit, stuck-1 forces the high-then-low pattern, stuck-0 forces the low-then-high pattern, and invert flips both halves.
- R6: With the parity field selected, the parity bit, which is the 20th bit-time and carries odd parity over the data, is corrupted by the same three rules as a data bit.
- R7: The fault code is 2 bits: 0 off, 1 stuck-0, 2 stuck-1, 3 invert. Code 0 leaves every word untouched.
- R8: The event count goes up by exactly one for each armed word and does not change for words that are not armed.
- R9: Configuration changes made while a word is in progress have no effect on that word.
- R10: A word that follows the previous word's parity bit with no idle gap is framed and classified as a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one half-bit lasts HALF_CYC cycles |
| rst | input | 1 | Synchronous active-high reset |
| line_p_i | input | 1 | Incoming stream, driven-high indicator |
| line_n_i | input | 1 | Incoming stream, driven-low indicator |
| cfg_fault_i | input | 2 | Fault code (R7) |
| cfg_class_i | input | 3 | Word-class enables: [0] command, [1] status, [2] data |
| cfg_src_term_i | input | 1 | 1 when the upstream transmitter is a terminal |
| cfg_sync_en_i | input | 1 | Select the sync field |
| cfg_par_en_i | input | 1 | Select the parity bit |
| cfg_dmask_i | input | 16 | Data-bit select mask, bit i selects data bit i |
| line_p_o | output | 1 | Outgoing stream, driven-high indicator |
| line_n_o | output | 1 | Outgoing stream, driven-low indicator |
| inj_count_o | output | CNT_W | Number of armed words seen |

## Verification
The situation that is hardest to reach from the ports is a word boundary with no idle gap between two words. The framer must close one word on its 40th half-bit and reopen on the very next sample, and it must also reclassify the second word from that sample. The bench sends a high-first word that is not targeted and follows it at once with a data word that is targeted. It then checks that only the second word is altered and that the count rises by exactly one. A second hard case is a configuration change in the middle of a word. To reach it, the bench switches the fault code off halfway through a data field and expects the original fault pattern through the end of that word.

// File: rtl/miw_pkg.sv
package miw_pkg;

    localparam int SLOTS       = 40;  // half-bit slots in one word
    localparam int SYNC_SLOTS  = 6;
    localparam int PAR_SLOT    = 38;
    localparam int DATA_BITS   = 16;
    localparam int SLOT_W      = $clog2(SLOTS);

    typedef enum logic [1:0] {
        FLT_OFF = 2'd0,
        FLT_S0  = 2'd1,
        FLT_S1  = 2'd2,
        FLT_INV = 2'd3
    } fault_e;

    typedef struct packed {
        fault_e                 kind;
        logic [2:0]             classes;   // [0] cmd [1] status [2] data
        logic                   src_term;
        logic                   sync_en;
        logic                   par_en;
        logic [DATA_BITS-1:0]   dmask;
    } inj_cfg_t;

    // Word is armed when a fault is chosen, its class is enabled and a field is picked.
    function automatic logic word_armed(inj_cfg_t c, logic hi_first);
        logic cls_on;
        cls_on = hi_first ? (c.src_term ? c.classes[1] : c.classes[0]) : c.classes[2];
        return (c.kind != FLT_OFF) && cls_on && (c.sync_en || c.par_en || (|c.dmask));
    endfunction

    // Level a forced slot takes; one_lvl is the level this slot carries for a logical 1.
    function automatic logic forced_level(fault_e k, logic in_lvl, logic one_lvl);
        case (k)
            FLT_S0:  return !one_lvl;
            FLT_S1:  return one_lvl;
            FLT_INV: return !in_lvl;
            default: return in_lvl;
        endcase
    endfunction

endpackage

// File: rtl/miw_framer.sv
module miw_framer
    import miw_pkg::*;
#(
    parameter int HALF_CYC = 50
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 drv_i,
    input  logic                 lvl_i,
    input  inj_cfg_t             cfg_i,
    output logic                 start_o,
    output logic                 inword_o,
    output logic [SLOT_W-1:0]    slot_o,
    output logic                 hi_o,
    output inj_cfg_t             cfg_o
);
    localparam int PH_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic               act_q;
    logic [PH_W-1:0]    ph_q;
    logic [SLOT_W-1:0]  slot_q;
    logic               hi_q;
    inj_cfg_t           cfg_q;

    logic [PH_W-1:0]    cur_ph;
    logic [SLOT_W-1:0]  cur_slot;

    assign start_o  = drv_i && !act_q;
    assign inword_o = act_q || start_o;
    assign cur_ph   = act_q ? ph_q   : '0;
    assign cur_slot = act_q ? slot_q : '0;
    assign slot_o   = cur_slot;
    assign hi_o     = start_o ? lvl_i : hi_q;
    assign cfg_o    = start_o ? cfg_i : cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= 1'b0;
            ph_q   <= '0;
            slot_q <= '0;
            hi_q   <= 1'b0;
            cfg_q  <= '0;
        end else if (inword_o) begin
            if (start_o) begin
                hi_q  <= lvl_i;
                cfg_q <= cfg_i;
            end
            if (cur_ph == PH_W'(HALF_CYC - 1)) begin
                ph_q <= '0;
                if (cur_slot == SLOT_W'(SLOTS - 1)) begin
                    act_q  <= 1'b0;
                    slot_q <= '0;
                end else begin
                    act_q  <= 1'b1;
                    slot_q <= cur_slot + 1'b1;
                end
            end else begin
                act_q  <= 1'b1;
                ph_q   <= cur_ph + 1'b1;
                slot_q <= cur_slot;
            end
        end
    end

    // R10: framing counters stay inside one word
    assert_slot_range_R10: assert property (@(posedge clk) disable iff (rst)
        slot_q < SLOT_W'(SLOTS));
    assert_phase_range_R10: assert property (@(posedge clk) disable iff (rst)
        ph_q <= PH_W'(HALF_CYC - 1));
    // R9: latched configuration holds for the whole word
    assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && act_q && $past(act_q)) |-> $stable(cfg_q));

endmodule

// File: rtl/miw_corrupt.sv
module miw_corrupt
    import miw_pkg::*;
(
    input  logic                 inword_i,
    input  logic                 drv_i,
    input  logic                 lvl_i,
    input  logic [SLOT_W-1:0]    slot_i,
    input  logic                 hi_i,
    input  inj_cfg_t             cfg_i,
    output logic                 armed_o,
    output logic                 lvl_o
);
    logic               in_sync;
    logic               in_par;
    logic [SLOT_W-1:0]  rev;
    logic               data_sel;
    logic               field_sel;
    logic               one_lvl;

    assign armed_o  = word_armed(cfg_i, hi_i);
    assign in_sync  = slot_i < SLOT_W'(SYNC_SLOTS);
    assign in_par   = slot_i >= SLOT_W'(PAR_SLOT);
    // 37 - slot: bits [5:1] give the data-bit number for slots 6..37
    assign rev      = SLOT_W'(PAR_SLOT - 1) - slot_i;
    assign data_sel = |(cfg_i.dmask & (16'd1 << rev[SLOT_W-1:1]));

    always_comb begin
        if (in_sync) begin
            field_sel = cfg_i.sync_en;
            one_lvl   = slot_i < SLOT_W'(SYNC_SLOTS / 2);
        end else if (in_par) begin
            field_sel = cfg_i.par_en;
            one_lvl   = !slot_i[0];
        end else begin
            field_sel = data_sel;
            one_lvl   = !slot_i[0];
        end
    end

    always_comb begin
        lvl_o = lvl_i;
        if (inword_i && drv_i && armed_o && field_sel)
            lvl_o = forced_level(cfg_i.kind, lvl_i, one_lvl);
    end

endmodule

// File: rtl/miw_event_ctr.sv
module miw_event_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             armed_i,
    output logic [CNT_W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (rst)
            count_o <= '0;
        else if (start_i && armed_i)
            count_o <= count_o + 1'b1;
    end

    // R8: at most one step per clock
    assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1));

endmodule

// File: rtl/mil_word_injector.sv
module mil_word_injector
    import miw_pkg::*;
#(
    parameter int HALF_CYC = 50,
    parameter int CNT_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_p_i,
    input  logic             line_n_i,
    input  logic [1:0]       cfg_fault_i,
    input  logic [2:0]       cfg_class_i,
    input  logic             cfg_src_term_i,
    input  logic             cfg_sync_en_i,
    input  logic             cfg_par_en_i,
    input  logic [15:0]      cfg_dmask_i,
    output logic             line_p_o,
    output logic             line_n_o,
    output logic [CNT_W-1:0] inj_count_o
);
    inj_cfg_t           cfg_in;
    inj_cfg_t           cfg_cur;
    logic               drv;
    logic               start;
    logic               inword;
    logic [SLOT_W-1:0]  slot;
    logic               hi_first;
    logic               armed;
    logic               new_lvl;

    assign cfg_in.kind     = fault_e'(cfg_fault_i);
    assign cfg_in.classes  = cfg_class_i;
    assign cfg_in.src_term = cfg_src_term_i;
    assign cfg_in.sync_en  = cfg_sync_en_i;
    assign cfg_in.par_en   = cfg_par_en_i;
    assign cfg_in.dmask    = cfg_dmask_i;

    assign drv = line_p_i ^ line_n_i;

    miw_framer #(.HALF_CYC(HALF_CYC)) u_framer (
        .clk(clk), .rst(rst), .drv_i(drv), .lvl_i(line_p_i), .cfg_i(cfg_in),
        .start_o(start), .inword_o(inword), .slot_o(slot), .hi_o(hi_first), .cfg_o(cfg_cur)
    );

    miw_corrupt u_corrupt (
        .inword_i(inword), .drv_i(drv), .lvl_i(line_p_i), .slot_i(slot),
        .hi_i(hi_first), .cfg_i(cfg_cur), .armed_o(armed), .lvl_o(new_lvl)
    );

    miw_event_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst(rst), .start_i(start), .armed_i(armed), .count_o(inj_count_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            line_p_o <= 1'b0;
            line_n_o <= 1'b0;
        end else if (drv) begin
            line_p_o <= new_lvl;
            line_n_o <= !new_lvl;
        end else begin
            line_p_o <= line_p_i;
            line_n_o <= line_n_i;
        end
    end

    // R2: undriven samples are copied one clock later
    assert_idle_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(drv)) |-> (line_p_o == $past(line_p_i) && line_n_o == $past(line_n_i)));
    // R2: a word that is not armed is copied unchanged
    assert_unarmed_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(inword) && !$past(armed)) |->
        (line_p_o == $past(line_p_i) && line_n_o == $past(line_n_i)));
    // R2: a driven input always leaves as a driven output
    assert_driven_stays_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(drv)) |-> (line_p_o != line_n_o));

endmodule

// File: tb/tb_mil_word_injector.sv
module tb_mil_word_injector;
    localparam int HALF  = 4;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lp = 1'b0, ln = 1'b0;
    logic [23:0] cfg_v = '0;   // {fault[1:0], class[2:0], src, sync, par, mask[15:0]}
    logic p_o, n_o;
    logic [CNT_W-1:0] cnt_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mil_word_injector #(.HALF_CYC(HALF), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .line_p_i(lp), .line_n_i(ln),
        .cfg_fault_i(cfg_v[23:22]), .cfg_class_i(cfg_v[21:19]), .cfg_src_term_i(cfg_v[18]),
        .cfg_sync_en_i(cfg_v[17]), .cfg_par_en_i(cfg_v[16]), .cfg_dmask_i(cfg_v[15:0]),
        .line_p_o(p_o), .line_n_o(n_o), .inj_count_o(cnt_o)
    );

    // entry: {hi, data[15:0], cfg[23:0]}
    localparam int NV = 11;
    localparam logic [40:0] VEC [NV] = '{
        {1'b1, 16'hA5C3, 2'd0, 3'b111, 1'b0, 1'b1, 1'b1, 16'hFFFF},  // R7 off
        {1'b1, 16'h1234, 2'd1, 3'b001, 1'b0, 1'b1, 1'b0, 16'h0000},  // R4 s0 sync cmd
        {1'b1, 16'h1234, 2'd2, 3'b001, 1'b1, 1'b1, 1'b0, 16'h0000},  // R3 status not enabled
        {1'b1, 16'h0F0F, 2'd3, 3'b010, 1'b1, 1'b1, 1'b0, 16'h0000},  // R4 inv sync status
        {1'b0, 16'hFFFF, 2'd1, 3'b100, 1'b0, 1'b0, 1'b0, 16'h8001},  // R5 s0 data
        {1'b0, 16'h0000, 2'd2, 3'b100, 1'b0, 1'b0, 1'b0, 16'h00F0},  // R5 s1 data
        {1'b0, 16'h5A5A, 2'd3, 3'b100, 1'b0, 1'b0, 1'b1, 16'hFFFF},  // R5 R6 inv all
        {1'b1, 16'h0001, 2'd2, 3'b011, 1'b0, 1'b0, 1'b1, 16'h0000},  // R6 s1 parity
        {1'b0, 16'h3333, 2'd3, 3'b011, 1'b0, 1'b0, 1'b0, 16'hFFFF},  // R3 data not enabled
        {1'b1, 16'h8000, 2'd2, 3'b111, 1'b0, 1'b0, 1'b0, 16'h0000},  // R8 no field
        {1'b0, 16'h1111, 2'd2, 3'b100, 1'b0, 1'b1, 1'b0, 16'h0000}   // R4 s1 sync data
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R7";
            1, 3, 10: return "R4";
            2, 8: return "R3";
            4, 5: return "R5";
            6: return "R5 R6";
            7: return "R6";
            default: return "R8";
        endcase
    endfunction

    function automatic logic is_armed(logic hi, logic [23:0] c);
        logic cls;
        cls = hi ? (c[18] ? c[20] : c[19]) : c[21];
        return (c[23:22] != 2'd0) && cls && (c[17] || c[16] || (c[15:0] != 16'd0));
    endfunction

    function automatic logic [39:0] expect_lv(logic hi, logic [15:0] d, logic [23:0] c);
        logic [39:0] lv;
        logic sel, onel, par;
        for (int j = 0; j < 3; j++) begin lv[j] = hi; lv[j+3] = !hi; end
        for (int k = 0; k < 16; k++) begin
            lv[6+2*k] = d[15-k];
            lv[7+2*k] = !d[15-k];
        end
        par = ~^d;
        lv[38] = par; lv[39] = !par;
        if (is_armed(hi, c)) begin
            for (int j = 0; j < 40; j++) begin
                if (j < 6) begin sel = c[17]; onel = (j < 3); end
                else if (j >= 38) begin sel = c[16]; onel = (j == 38); end
                else begin sel = c[15 - (j-6)/2]; onel = ((j-6) % 2 == 0); end
                if (sel) begin
                    case (c[23:22])
                        2'd1: lv[j] = !onel;
                        2'd2: lv[j] = onel;
                        2'd3: lv[j] = !lv[j];
                        default: ;
                    endcase
                end
            end
        end
        return lv;
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            lp = 1'b0; ln = 1'b0;
        end
    endtask

    // Drives one word; samples each half-bit slot at its third clock.
    task automatic run_word(input logic hi, input logic [15:0] d, input logic do_mid,
                            input logic [23:0] mid_cfg, input logic chk_lat,
                            output logic [39:0] got, output int bad);
        logic [39:0] src;
        logic par;
        bad = 0;
        got = '0;
        for (int j = 0; j < 3; j++) begin src[j] = hi; src[j+3] = !hi; end
        for (int k = 0; k < 16; k++) begin src[6+2*k] = d[15-k]; src[7+2*k] = !d[15-k]; end
        par = ~^d;
        src[38] = par; src[39] = !par;
        for (int j = 0; j < 40; j++) begin
            for (int c = 0; c < HALF; c++) begin
                @(negedge clk);
                if (chk_lat && j == 0 && c == 0)
                    check(p_o == 1'b0 && n_o == 1'b0, "R2", "latency before first edge",
                          {62'd0, p_o, n_o}, 64'd0);
                if (chk_lat && j == 0 && c == 1)
                    check(p_o == hi && n_o == !hi, "R2", "one-clock latency",
                          {62'd0, p_o, n_o}, {62'd0, hi, !hi});
                if (c == 2) begin
                    got[j] = p_o;
                    if (p_o == n_o) bad++;
                end
                if (do_mid && j == 20 && c == 0) cfg_v = mid_cfg;
                lp = src[j]; ln = !src[j];
            end
        end
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [39:0] got, exp;
        logic [CNT_W-1:0] c0;
        logic [23:0] cf;
        int bad;

        // R1: reset state
        repeat (3) @(negedge clk);
        check(p_o == 1'b0 && n_o == 1'b0, "R1", "outputs in reset", {62'd0, p_o, n_o}, 64'd0);
        check(cnt_o == '0, "R1", "count in reset", 64'(cnt_o), 64'd0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(p_o == 1'b0 && n_o == 1'b0 && cnt_o == '0, "R1", "first clock after reset",
              {46'd0, cnt_o, p_o, n_o}, 64'd0);

        // R2: undriven pair passes through
        lp = 1'b1; ln = 1'b1;
        @(negedge clk);
        check(p_o && n_o, "R2", "both-high copied", {62'd0, p_o, n_o}, 64'd3);
        lp = 1'b0; ln = 1'b0;
        idle(3);

        // vector table
        for (int i = 0; i < NV; i++) begin
            cfg_v = VEC[i][23:0];
            c0 = cnt_o;
            run_word(VEC[i][40], VEC[i][39:24], 1'b0, '0, i == 0, got, bad);
            idle(3);
            exp = expect_lv(VEC[i][40], VEC[i][39:24], VEC[i][23:0]);
            check(got == exp && bad == 0, vec_tag(i), $sformatf("word levels vec %0d", i),
                  {24'd0, got}, {24'd0, exp});
            check(cnt_o == c0 + CNT_W'(is_armed(VEC[i][40], VEC[i][23:0])), "R8",
                  $sformatf("event count vec %0d", i), 64'(cnt_o),
                  64'(c0 + CNT_W'(is_armed(VEC[i][40], VEC[i][23:0]))));
        end

        // R9: mid-word switch to off is ignored
        cf = {2'd2, 3'b100, 1'b0, 1'b0, 1'b0, 16'h00FF};
        cfg_v = cf;
        c0 = cnt_o;
        run_word(1'b0, 16'h0000, 1'b1, {2'd0, 3'b000, 1'b0, 1'b0, 1'b0, 16'h0000}, 1'b0, got, bad);
        idle(3);
        exp = expect_lv(1'b0, 16'h0000, cf);
        check(got == exp && bad == 0, "R9", "mid-word config change", {24'd0, got}, {24'd0, exp});
        check(cnt_o == c0 + 1'b1, "R9", "count for mid-word case", 64'(cnt_o), 64'(c0 + 1'b1));

        // R10: back-to-back words, only the second one targeted
        cf = {2'd1, 3'b100, 1'b0, 1'b0, 1'b0, 16'hFFFF};
        cfg_v = cf;
        c0 = cnt_o;
        run_word(1'b1, 16'hFFFF, 1'b0, '0, 1'b0, got, bad);
        exp = expect_lv(1'b1, 16'hFFFF, cf);
        check(got == exp && bad == 0, "R10", "first contiguous word", {24'd0, got}, {24'd0, exp});
        run_word(1'b0, 16'hFFFF, 1'b0, '0, 1'b0, got, bad);
        idle(3);
        exp = expect_lv(1'b0, 16'hFFFF, cf);
        check(got == exp && bad == 0, "R10", "second contiguous word", {24'd0, got}, {24'd0, exp});
        check(cnt_o == c0 + 1'b1, "R10", "count across contiguous words", 64'(cnt_o), 64'(c0 + 1'b1));

        // R1: reset clears the count again
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        check(cnt_o == '0 && !p_o && !n_o, "R1", "re-reset", {46'd0, cnt_o, p_o, n_o}, 64'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule